// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block translates a physical address into the DRAM rank and channel that hold it. Two channels of four ranks each are described by programmable registers. Each rank has a cumulative upper boundary, counted in 32 MiB units, and a three-bit attribute that gives its page size or marks it unpopulated. Software loads these bytes through a simple write port. After that, any address presented with a valid strobe is resolved one clock later into a hit, a rank index, a channel and an out-of-range indication.

The block compares the two channels' configurations on its own and picks one of two decoding modes. In interleaved mode (`MODE_ILV`), the two channels are populated identically. Channel 0's boundaries are doubled to form system boundaries, and the channel is chosen by address bit 7. In asymmetric mode (`MODE_ASYM`), channel 0 occupies the bottom of the address space and channel 1 follows directly above it. The block also reports the total installed memory in 32 MiB units and flags reserved attribute codes. There is no sequencing state: the only transition is a one-cycle hop from the decode request to the registered result, and the mode is re-derived every cycle from the register contents.

Top module: `rank_addr_decoder`

## Requirements
- R1: After reset, all boundary and attribute registers read as zero. As a result `mode_ilv` is 1, `cfg_err` is 0, `total_units` is 0, and `res_valid`, `res_hit` and `res_oor` are 0.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` as follows, where n is the rank 0..3:
  - select n sets channel 0 boundary of rank n.
  - select 4+n sets channel 1 boundary of rank n.
  - selects 8 and 9 set channel 0's attributes for rank pairs 0/1 and 2/3.
  - selects 10 and 11 do the same for channel 1.
  - In an attribute byte, bits 2:0 belong to the even rank and bits 6:4 to the odd rank. Bits 7 and 3 are dropped.
  - Writes to selects 12..15 change nothing.
- R3: Attribute codes 3'b010, 3'b011 and 3'b100 mean populated, and 3'b000 means unpopulated. Every other code is reserved: it counts as unpopulated and drives `cfg_err` high while any such field is stored.
- R4: `mode_ilv` is 1 exactly when all four boundaries and all four attribute fields of channel 0 equal those of channel 1.
- R5: `total_units` equals twice channel 0's rank-3 boundary in interleaved mode. In asymmetric mode it equals the sum of both channels' rank-3 boundaries.
- R6: A request with `dec_valid` high produces `res_valid` high on the next cycle, with its results. When `res_valid` is low, `res_hit` and `res_oor` are low.
- R7: When the address unit (address bits 32:25) is at or above `total_units`, the result has `res_oor` set and `res_hit` clear.
- R8: The selected rank is the lowest-numbered rank whose boundary is greater than the address unit and greater than the previous rank's boundary. Rank 0's previous boundary counts as 0. A rank whose boundary equals its predecessor's is never selected.
- R9: In interleaved mode, channel 0's boundaries are doubled for the comparison, and `res_chan` equals address bit 7.
- R10: In asymmetric mode, an address unit below channel 0's rank-3 boundary selects channel 0. Otherwise channel 1 is selected, and its boundaries are compared against the unit minus channel 0's rank-3 boundary.
- R11: An in-range address whose selected rank has an unpopulated or reserved attribute, or for which no rank qualifies, gives `res_hit` 0 and `res_oor` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 4 | Register select |
| cfg_wr_data | input | 8 | Register write byte |
| dec_valid | input | 1 | Decode request strobe |
| dec_addr | input | 33 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_hit | output | 1 | Address maps to a populated rank |
| res_oor | output | 1 | Address at or beyond installed memory |
| res_rank | output | 2 | Selected rank within the channel |
| res_chan | output | 1 | Selected channel |
| mode_ilv | output | 1 | Channels identical, interleaved decoding |
| cfg_err | output | 1 | A reserved attribute code is stored |
| total_units | output | 9 | Installed memory in 32 MiB units |

## Verification
The decoder is driven with five configurations, each aimed at a different kind of bug:
- An asymmetric layout with an empty rank in each channel. This separates channel-0 from channel-1 addressing and exposes errors in the channel-1 offset subtraction.
- A matched layout that switches the block to interleaved mode. Toggling address bit 7 there shows whether boundaries are doubled and whether the channel bit is wired.
- A layout with a reserved attribute. This tells "in range but unpopulated" apart from "out of range".
- Non-monotonic boundaries. These show whether the rule against selecting a rank whose boundary is not above its predecessor's is applied.
- Writes to unused selects. These must leave every decode result unchanged.

The bench compares against a behavioural model on every cycle. Addresses are swept across each boundary value, one unit below it and above total memory.

// File: rtl/rank_dec_pkg.sv
package rank_dec_pkg;

    typedef enum logic [2:0] {
        ATTR_NONE = 3'b000,
        ATTR_4K   = 3'b010,
        ATTR_8K   = 3'b011,
        ATTR_16K  = 3'b100
    } attr_code_e;

    typedef enum logic {
        MODE_ASYM = 1'b0,
        MODE_ILV  = 1'b1
    } dec_mode_e;

    function automatic logic attr_populated(input logic [2:0] code);
        return (code == ATTR_4K) || (code == ATTR_8K) || (code == ATTR_16K);
    endfunction

    function automatic logic attr_reserved(input logic [2:0] code);
        return (code != ATTR_NONE) && !attr_populated(code);
    endfunction

endpackage

// File: rtl/rank_cfg_regs.sv
module rank_cfg_regs #(
    parameter int RANKS = 4,
    parameter int BW    = 8,
    parameter int SEL_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [7:0]                 wr_data,
    output logic [RANKS-1:0][BW-1:0]   bnd_c0,
    output logic [RANKS-1:0][BW-1:0]   bnd_c1,
    output logic [RANKS-1:0][2:0]      att_c0,
    output logic [RANKS-1:0][2:0]      att_c1
);
    localparam int PAIRS     = RANKS / 2;
    localparam int ATT0_BASE = 2 * RANKS;
    localparam int ATT1_BASE = 2 * RANKS + PAIRS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bnd_c0 <= '0;
            bnd_c1 <= '0;
            att_c0 <= '0;
            att_c1 <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < RANKS; r++) begin
                if (int'(wr_sel) == r)         bnd_c0[r] <= wr_data[BW-1:0];
                if (int'(wr_sel) == RANKS + r) bnd_c1[r] <= wr_data[BW-1:0];
            end
            for (int p = 0; p < PAIRS; p++) begin
                if (int'(wr_sel) == ATT0_BASE + p) begin
                    att_c0[2*p]   <= wr_data[2:0];
                    att_c0[2*p+1] <= wr_data[6:4];
                end
                if (int'(wr_sel) == ATT1_BASE + p) begin
                    att_c1[2*p]   <= wr_data[2:0];
                    att_c1[2*p+1] <= wr_data[6:4];
                end
            end
        end
    end

    // R2: without a write strobe the configuration holds
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bnd_c0) && $stable(bnd_c1) && $stable(att_c0) && $stable(att_c1)));

endmodule

// File: rtl/rank_mode_detect.sv
module rank_mode_detect
    import rank_dec_pkg::*;
#(
    parameter int RANKS = 4,
    parameter int BW    = 8
) (
    input  logic [RANKS-1:0][BW-1:0]   bnd_c0,
    input  logic [RANKS-1:0][BW-1:0]   bnd_c1,
    input  logic [RANKS-1:0][2:0]      att_c0,
    input  logic [RANKS-1:0][2:0]      att_c1,
    output dec_mode_e                  mode,
    output logic                       cfg_err,
    output logic [BW:0]                total
);
    always_comb begin
        mode = ((bnd_c0 == bnd_c1) && (att_c0 == att_c1)) ? MODE_ILV : MODE_ASYM;
        cfg_err = 1'b0;
        for (int r = 0; r < RANKS; r++) begin
            cfg_err = cfg_err | attr_reserved(att_c0[r]) | attr_reserved(att_c1[r]);
        end
        if (mode == MODE_ILV)
            total = {bnd_c0[RANKS-1], 1'b0};
        else
            total = {1'b0, bnd_c0[RANKS-1]} + {1'b0, bnd_c1[RANKS-1]};
    end
endmodule

// File: rtl/rank_search.sv
module rank_search
    import rank_dec_pkg::*;
#(
    parameter int RANKS = 4,
    parameter int UW    = 9,
    localparam int RIW  = $clog2(RANKS)
) (
    input  logic [RANKS-1:0][UW-1:0]   bnd,
    input  logic [RANKS-1:0][2:0]      att,
    input  logic [UW-1:0]              unit,
    output logic                       found,
    output logic [RIW-1:0]             idx,
    output logic                       pop
);
    logic [RANKS-1:0] cand;

    for (genvar r = 0; r < RANKS; r++) begin : g_cand
        if (r == 0) begin : g_first
            assign cand[r] = (bnd[r] > unit) && (bnd[r] != '0);
        end else begin : g_rest
            assign cand[r] = (bnd[r] > unit) && (bnd[r] > bnd[r-1]);
        end
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        pop   = 1'b0;
        for (int r = RANKS - 1; r >= 0; r--) begin
            if (cand[r]) begin
                found = 1'b1;
                idx   = RIW'(r);
                pop   = attr_populated(att[r]);
            end
        end
    end
endmodule

// File: rtl/rank_addr_decoder.sv
module rank_addr_decoder
    import rank_dec_pkg::*;
#(
    parameter int ADDR_W   = 33,
    parameter int UNIT_LSB = 25,
    parameter int BW       = 8,
    parameter int RANKS    = 4,
    parameter int CHAN_BIT = 7,
    localparam int SEL_W   = $clog2(4 * RANKS),
    localparam int UW      = BW + 1,
    localparam int RIW     = $clog2(RANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [7:0]        cfg_wr_data,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_oor,
    output logic [RIW-1:0]    res_rank,
    output logic              res_chan,
    output logic              mode_ilv,
    output logic              cfg_err,
    output logic [UW-1:0]     total_units
);
    logic [RANKS-1:0][BW-1:0] bnd_c0, bnd_c1;
    logic [RANKS-1:0][2:0]    att_c0, att_c1;
    dec_mode_e                mode;

    rank_cfg_regs #(.RANKS(RANKS), .BW(BW), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .bnd_c0(bnd_c0), .bnd_c1(bnd_c1),
        .att_c0(att_c0), .att_c1(att_c1)
    );

    rank_mode_detect #(.RANKS(RANKS), .BW(BW)) u_mode (
        .bnd_c0(bnd_c0), .bnd_c1(bnd_c1), .att_c0(att_c0), .att_c1(att_c1),
        .mode(mode), .cfg_err(cfg_err), .total(total_units)
    );

    assign mode_ilv = (mode == MODE_ILV);

    logic [UW-1:0]             unit, top0, s_unit;
    logic [RANKS-1:0][UW-1:0]  s_bnd;
    logic [RANKS-1:0][2:0]     s_att;
    logic                      s_chan, s_found, s_pop, oor_c;
    logic [RIW-1:0]            s_idx;

    assign unit = UW'(dec_addr[ADDR_W-1:UNIT_LSB]);
    assign top0 = {1'b0, bnd_c0[RANKS-1]};

    always_comb begin
        s_unit = unit;
        s_chan = 1'b0;
        s_att  = att_c0;
        for (int r = 0; r < RANKS; r++) s_bnd[r] = {1'b0, bnd_c0[r]};
        unique case (mode)
            MODE_ILV: begin
                for (int r = 0; r < RANKS; r++) s_bnd[r] = {bnd_c0[r], 1'b0};
                s_chan = dec_addr[CHAN_BIT];
            end
            MODE_ASYM: begin
                if (unit >= top0) begin
                    for (int r = 0; r < RANKS; r++) s_bnd[r] = {1'b0, bnd_c1[r]};
                    s_att  = att_c1;
                    s_unit = unit - top0;
                    s_chan = 1'b1;
                end
            end
        endcase
    end

    rank_search #(.RANKS(RANKS), .UW(UW)) u_search (
        .bnd(s_bnd), .att(s_att), .unit(s_unit),
        .found(s_found), .idx(s_idx), .pop(s_pop)
    );

    assign oor_c = (unit >= total_units);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_oor   <= 1'b0;
            res_rank  <= '0;
            res_chan  <= 1'b0;
        end else begin
            res_valid <= dec_valid;
            res_hit   <= dec_valid && !oor_c && s_found && s_pop;
            res_oor   <= dec_valid && oor_c;
            if (dec_valid) begin
                res_rank <= s_idx;
                res_chan <= s_chan;
            end
        end
    end

    // R6: a request is answered on the next cycle
    a_r6_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> res_valid);
    // R6: flags stay quiet without a result
    a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_oor));
    // R7: out of range never counts as a hit
    a_r7_oor_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_oor |-> !res_hit);
    // R9: interleaved channel follows the address bit
    a_r9_ilv_channel_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && mode_ilv) |=> (!res_hit || (res_chan == $past(dec_addr[CHAN_BIT]))));

endmodule

// File: tb/rank_addr_decoder_tb_top.sv
module rank_addr_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_sel = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        dec_valid = 1'b0;
    logic [32:0] dec_addr = '0;
    logic        res_valid, res_hit, res_oor, res_chan, mode_ilv, cfg_err;
    logic [1:0]  res_rank;
    logic [8:0]  total_units;

    always #10 clk = ~clk;

    rank_addr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .dec_valid(dec_valid), .dec_addr(dec_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_oor(res_oor),
        .res_rank(res_rank), .res_chan(res_chan), .mode_ilv(mode_ilv),
        .cfg_err(cfg_err), .total_units(total_units)
    );

    int checks = 0;
    int fails  = 0;
    int mb [2][4];
    int ma [2][4];
    string hit_tag = "R8";

    // pending expectation for the next sampled result
    int  q_valid [$];
    int  q_res   [$];
    string q_tag [$];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit m_ilv();
        for (int c = 0; c < 4; c++)
            if (mb[0][c] != mb[1][c] || ma[0][c] != ma[1][c]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_total();
        if (m_ilv()) return 2 * mb[0][3];
        return mb[0][3] + mb[1][3];
    endfunction

    function automatic bit m_err();
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 4; r++)
                if (!(ma[c][r] inside {0, 2, 3, 4})) return 1'b1;
        return 1'b0;
    endfunction

    // returns hit*16 + oor*8 + rank*2 + chan
    function automatic int m_decode(int u, bit a7);
        int ch, scale, base, prev, e;
        if (u >= m_total()) return 8;
        if (m_ilv()) begin ch = 0; scale = 2; base = 0; end
        else if (u < mb[0][3]) begin ch = 0; scale = 1; base = 0; end
        else begin ch = 1; scale = 1; base = mb[0][3]; end
        prev = 0;
        for (int r = 0; r < 4; r++) begin
            e = base + scale * mb[ch][r];
            if (e > u && mb[ch][r] > prev) begin
                if (ma[ch][r] inside {2, 3, 4})
                    return 16 + r * 2 + (m_ilv() ? int'(a7) : ch);
                return 0;
            end
            prev = mb[ch][r];
        end
        return 0;
    endfunction

    task automatic m_write(int sel, int data);
        if (sel < 4) mb[0][sel] = data;
        else if (sel < 8) mb[1][sel-4] = data;
        else if (sel < 12) begin
            ma[(sel-8)/2][((sel-8)%2)*2]   = data & 7;
            ma[(sel-8)/2][((sel-8)%2)*2+1] = (data >> 4) & 7;
        end
    endtask

    task automatic compare_now();
        int v, e;
        string t;
        v = q_valid.pop_front();
        e = q_res.pop_front();
        t = q_tag.pop_front();
        chk("R6", "res_valid", int'(res_valid), v);
        if (v == 1) begin
            chk("R7", "res_oor", int'(res_oor), (e >> 3) & 1);
            chk(t, "res_hit", int'(res_hit), (e >> 4) & 1);
            if (((e >> 4) & 1) == 1) begin
                chk("R8", "res_rank", int'(res_rank), (e >> 1) & 3);
                chk(m_ilv() ? "R9" : "R10", "res_chan", int'(res_chan), e & 1);
            end
        end else begin
            chk("R6", "res_hit idle", int'(res_hit), 0);
            chk("R6", "res_oor idle", int'(res_oor), 0);
        end
        chk("R4", "mode_ilv", int'(mode_ilv), int'(m_ilv()));
        chk("R3", "cfg_err", int'(cfg_err), int'(m_err()));
        chk("R5", "total_units", int'(total_units), m_total());
    endtask

    // one cycle: check at negedge, drive, advance to next negedge
    task automatic cyc(bit we, int sel, int data, bit dv, int u, bit a7);
        compare_now();
        cfg_wr_en   = we;
        cfg_wr_sel  = 4'(sel);
        cfg_wr_data = 8'(data);
        dec_valid   = dv;
        dec_addr    = {8'(u), 17'h0A5C3, a7, 7'h15};
        q_valid.push_back(int'(dv));
        q_res.push_back(dv ? m_decode(u, a7) : 0);
        q_tag.push_back(hit_tag);
        if (we) m_write(sel, data);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        cyc(1'b1, sel, data, 1'b0, 0, 1'b0);
    endtask

    task automatic dec(int u, bit a7);
        cyc(1'b0, 0, 0, 1'b1, u, a7);
    endtask

    task automatic sweep();
        int pts [$];
        pts = {0, 1, 3, 4, 5, 7, 8, 9, 11, 12, 15, 16, 17, 21, 22, 23, 31, 32, 33, 255};
        foreach (pts[i]) begin
            dec(pts[i], 1'b0);
            dec(pts[i], 1'b1);
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 4; r++) begin mb[c][r] = 0; ma[c][r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "mode_ilv", int'(mode_ilv), 1);
        chk("R1", "cfg_err", int'(cfg_err), 0);
        chk("R1", "total_units", int'(total_units), 0);
        q_valid.push_back(0); q_res.push_back(0); q_tag.push_back("R1");
        dec(0, 1'b0);
        dec(5, 1'b0);

        // asymmetric layout: R10, R8, R11
        hit_tag = "R10";
        wr(0, 4); wr(1, 8); wr(2, 8); wr(3, 16);
        wr(4, 2); wr(5, 6); wr(6, 6); wr(7, 6);
        wr(8, 8'hB2); wr(9, 8'hC8 & 8'h48); wr(10, 8'h22); wr(11, 8'h00);
        sweep();

        // interleaved layout: R9, R5, R4
        hit_tag = "R9";
        wr(4, 4); wr(5, 8); wr(6, 8); wr(7, 16);
        wr(10, 8'hB2); wr(11, 8'h48 & 8'h40);
        wr(9, 8'h40);
        sweep();

        // writes to unused selects must not disturb anything: R2
        hit_tag = "R2";
        wr(12, 8'hFF); wr(13, 8'h11); wr(14, 8'h00); wr(15, 8'h77);
        sweep();

        // reserved attribute code: R3 and R11
        hit_tag = "R11";
        wr(8, 8'h52);
        sweep();
        wr(8, 8'h32);

        // non-monotonic boundaries: R8
        hit_tag = "R8";
        wr(0, 8); wr(1, 4); wr(2, 12); wr(3, 16);
        wr(4, 3); wr(5, 3); wr(6, 9); wr(7, 20);
        sweep();

        compare_now();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule